// File: doc/BRIEF.md
# Low-Power Mode and Wake Controller

This block puts a processor core into one of three sleep levels when the core issues its idle-instruction strobe. It then brings the core back to run mode. The sleep level comes from a 2-bit mode field in a control register. Each level keeps a different set of clocks running and accepts a different set of wake causes. The block drives three clock-enable outputs: the oscillator, the core clock input and the system clock output. It also drives a sleep flag. The oscillator, the PLL and the clock gates are outside the block; only their enables are modelled. The block has no effect on any other output pin of the device.

Software sets up two registers through a simple write port. The control register holds the mode and a qualification count. The select register is a mask that names which general-purpose inputs may wake the device. In the middle sleep level, a selected input must stay high for a programmed number of cycles before the wake is taken. In the deepest level the oscillator is stopped, so a selected input wakes the device at once. The clocks then come back one per cycle, oscillator first. An external reset request returns the block to run mode from any state in one cycle.

Top module: `lpm_wake_ctrl`

## Requirements
- R1: After `rst`, all three enables are 1, `sleeping` is 0, the mode and the qualification count are 0, and the select mask is 0.
- R2: A write with `cfg_addr`=0 loads the mode from `cfg_wdata[1:0]` and the qualification count from `cfg_wdata[7:2]`. A write with `cfg_addr`=1 loads the 32-bit select mask. Mode 00 selects light sleep, 01 selects standby, and 10 or 11 selects halt.
- R3: `idle_req` in run mode with mode 00 makes `sleeping` 1 on the next edge, with all three enables still 1.
- R4: Entering standby gives `osc_en`=1, `clkin_en`=0 and `sysclk_en`=0. Entering halt gives all three enables 0. In both cases `sleeping` is 1, and the outputs change on the edge that samples `idle_req`.
- R5: In light sleep, `int_pend`, `wdog_int` or `nmi` returns the block to run mode on the next edge. `dbg_wake` and selected inputs have no effect in light sleep.
- R6: In standby, `wdog_int`, `nmi`, `dbg_wake` or a qualified selected input starts the wake. `int_pend` has no effect in standby.
- R7: In halt, `nmi`, `dbg_wake` or any selected input wakes the block with no qualification. `wdog_int` and `int_pend` have no effect in halt.
- R8: In standby, a selected input wakes the block only after it has been sampled high on count+2 consecutive edges. If the input drops, the count restarts.
- R9: Only inputs whose mask bit is 1 can cause a wake. Unselected inputs have no effect.
- R10: Wake from halt gives `osc_en` on the wake edge, then `clkin_en` one edge later, then `sysclk_en` with `sleeping`=0 one edge after that. Wake from standby gives `clkin_en` on the wake edge, then `sysclk_en` with `sleeping`=0 one edge later. `sysclk_en`=1 always implies `clkin_en`=1 and `osc_en`=1.
- R11: `ext_rst` in any state gives all enables 1 and `sleeping`=0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_req | input | 1 | Idle-instruction strobe from the core |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 1 | 0: mode control, 1: wake select mask |
| cfg_wdata | input | 32 | Register write data |
| gpio_in | input | 32 | General-purpose wake input lines |
| int_pend | input | 1 | An enabled interrupt is pending |
| nmi | input | 1 | Non-maskable interrupt request |
| ext_rst | input | 1 | External reset request |
| wdog_int | input | 1 | Watchdog interrupt |
| dbg_wake | input | 1 | Debugger wake request |
| osc_en | output | 1 | Oscillator enable |
| clkin_en | output | 1 | Core clock input enable |
| sysclk_en | output | 1 | System clock output enable |
| sleeping | output | 1 | Core is in a low-power state or waking |

## Verification
All outputs are registered, so every result is due on the first edge after the input that causes it. A halt wake takes three edges in all and a standby wake takes two. A standby input wake takes count+2 edges of the line held high. The bench drives one input set per cycle, one nanosecond after the rising edge. In the same step it queues the output vector expected after the next edge. The monitor compares the queue entry at the falling edge that follows. Each multi-cycle sequence is therefore written as one queued entry per edge, and a wake that comes one edge early or late is reported.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int LPM_MODE_W = 2;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_IDLE,
    ST_STBY,
    ST_HALT,
    ST_WOSC,
    ST_WCLK
  } lpm_state_e;

  // {osc, clkin, sysclk, sleeping}
  function automatic logic [3:0] en_of(input lpm_state_e s);
    case (s)
      ST_RUN:  return 4'b1110;
      ST_IDLE: return 4'b1111;
      ST_STBY: return 4'b1001;
      ST_HALT: return 4'b0001;
      ST_WOSC: return 4'b1001;
      ST_WCLK: return 4'b1101;
      default: return 4'b1110;
    endcase
  endfunction

  function automatic lpm_state_e sleep_of(input logic [LPM_MODE_W-1:0] m);
    if (m[1])      return ST_HALT;
    else if (m[0]) return ST_STBY;
    else           return ST_IDLE;
  endfunction
endpackage

// File: rtl/lpm_cfg_regs.sv
module lpm_cfg_regs #(
  parameter int DATA_W = 32,
  parameter int QUAL_W = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic                          addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [lpm_pkg::LPM_MODE_W-1:0] mode,
  output logic [QUAL_W-1:0]             qual,
  output logic [DATA_W-1:0]             mask
);
  localparam int MW = lpm_pkg::LPM_MODE_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= '0;
      qual <= '0;
      mask <= '0;
    end else if (we) begin
      if (!addr) begin
        mode <= wdata[MW-1:0];
        qual <= wdata[MW+QUAL_W-1:MW];
      end else begin
        mask <= wdata;
      end
    end
  end
endmodule

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual #(
  parameter int QUAL_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              hit,
  input  logic [QUAL_W-1:0] limit,
  output logic              ok
);
  localparam int CW = QUAL_W + 1;

  logic [CW-1:0] run_len;

  assign ok = arm && hit && (run_len == (CW'(limit) + CW'(1)));

  always_ff @(posedge clk) begin
    if (rst || !arm || !hit) run_len <= '0;
    else if (!ok)            run_len <= run_len + CW'(1);
  end
endmodule

// File: rtl/lpm_wake_mux.sv
module lpm_wake_mux
  import lpm_pkg::*;
(
  input  lpm_state_e st,
  input  logic       int_pend,
  input  logic       nmi,
  input  logic       wdog_int,
  input  logic       dbg_wake,
  input  logic       gpio_hit,
  input  logic       gpio_ok,
  output logic       wake
);
  always_comb begin
    case (st)
      ST_IDLE: wake = int_pend | wdog_int | nmi;
      ST_STBY: wake = wdog_int | nmi | dbg_wake | gpio_ok;
      ST_HALT: wake = nmi | dbg_wake | gpio_hit;
      default: wake = 1'b0;
    endcase
  end
endmodule

// File: rtl/lpm_wake_ctrl.sv
module lpm_wake_ctrl
  import lpm_pkg::*;
#(
  parameter int GPIO_W = 32,
  parameter int QUAL_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idle_req,
  input  logic              cfg_we,
  input  logic              cfg_addr,
  input  logic [GPIO_W-1:0] cfg_wdata,
  input  logic [GPIO_W-1:0] gpio_in,
  input  logic              int_pend,
  input  logic              nmi,
  input  logic              ext_rst,
  input  logic              wdog_int,
  input  logic              dbg_wake,
  output logic              osc_en,
  output logic              clkin_en,
  output logic              sysclk_en,
  output logic              sleeping
);
  logic [LPM_MODE_W-1:0] mode_q;
  logic [QUAL_W-1:0]     qual_q;
  logic [GPIO_W-1:0]     sel_q;
  logic                  gpio_hit, gpio_ok, wake;
  lpm_state_e            st_q, st_d;

  lpm_cfg_regs #(.DATA_W(GPIO_W), .QUAL_W(QUAL_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .mode(mode_q), .qual(qual_q), .mask(sel_q)
  );

  assign gpio_hit = |(gpio_in & sel_q);

  lpm_wake_qual #(.QUAL_W(QUAL_W)) u_qual (
    .clk(clk), .rst(rst), .arm(st_q == ST_STBY), .hit(gpio_hit),
    .limit(qual_q), .ok(gpio_ok)
  );

  lpm_wake_mux u_mux (
    .st(st_q), .int_pend(int_pend), .nmi(nmi), .wdog_int(wdog_int),
    .dbg_wake(dbg_wake), .gpio_hit(gpio_hit), .gpio_ok(gpio_ok), .wake(wake)
  );

  always_comb begin
    st_d = st_q;
    if (ext_rst) st_d = ST_RUN;
    else begin
      case (st_q)
        ST_RUN:  if (idle_req) st_d = sleep_of(mode_q);
        ST_IDLE: if (wake) st_d = ST_RUN;
        ST_STBY: if (wake) st_d = ST_WCLK;
        ST_HALT: if (wake) st_d = ST_WOSC;
        ST_WOSC: st_d = ST_WCLK;
        ST_WCLK: st_d = ST_RUN;
        default: st_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_RUN;
      {osc_en, clkin_en, sysclk_en, sleeping} <= 4'b1110;
    end else begin
      st_q <= st_d;
      {osc_en, clkin_en, sysclk_en, sleeping} <= en_of(st_d);
    end
  end
endmodule

// File: rtl/lpm_wake_ctrl_chk.sv
module lpm_wake_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        idle_req,
  input logic        ext_rst,
  input logic        wdog_int,
  input logic        int_pend,
  input logic        nmi,
  input logic        dbg_wake,
  input logic        gpio_hit,
  input logic [1:0]  mode,
  input logic        osc_en,
  input logic        clkin_en,
  input logic        sysclk_en,
  input logic        sleeping
);
  // R11
  ext_rst_run_chk: assert property (@(posedge clk) disable iff (rst)
    ext_rst |=> (osc_en && clkin_en && sysclk_en && !sleeping));

  // R10
  clk_order_chk: assert property (@(posedge clk) disable iff (rst)
    sysclk_en |-> (clkin_en && osc_en));

  // R10
  sys_after_in_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(sysclk_en) && !$past(ext_rst)) |-> $past(clkin_en));

  // R7
  halt_wdog_chk: assert property (@(posedge clk) disable iff (rst)
    (sleeping && !osc_en && wdog_int && !int_pend && !ext_rst && !nmi
     && !dbg_wake && !gpio_hit) |=> !osc_en);

  // R3
  idle_enter_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleeping && idle_req && !ext_rst && mode == 2'b00)
      |=> (sleeping && osc_en && clkin_en && sysclk_en));
endmodule

bind lpm_wake_ctrl lpm_wake_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .idle_req(idle_req), .ext_rst(ext_rst),
  .wdog_int(wdog_int), .int_pend(int_pend), .nmi(nmi), .dbg_wake(dbg_wake),
  .gpio_hit(gpio_hit), .mode(mode_q), .osc_en(osc_en), .clkin_en(clkin_en),
  .sysclk_en(sysclk_en), .sleeping(sleeping)
);

// File: tb/sim_lpm_wake_ctrl.sv
`timescale 1ns/1ps
module sim_lpm_wake_ctrl;
  localparam logic [3:0] RUN = 4'b1110, LIGHT = 4'b1111, STBY = 4'b1001,
                         HALT = 4'b0001, WOSC = 4'b1001, WCLK = 4'b1101;

  logic clk = 1'b0;
  logic rst, idle_req, cfg_we, cfg_addr, int_pend, nmi, ext_rst, wdog_int, dbg_wake;
  logic [31:0] cfg_wdata, gpio_in;
  logic osc_en, clkin_en, sysclk_en, sleeping;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];
  logic [3:0] e_v, a_v;
  string      e_t;

  always #2.5 clk = ~clk;

  lpm_wake_ctrl u0 (
    .clk(clk), .rst(rst), .idle_req(idle_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .gpio_in(gpio_in), .int_pend(int_pend), .nmi(nmi),
    .ext_rst(ext_rst), .wdog_int(wdog_int), .dbg_wake(dbg_wake), .osc_en(osc_en),
    .clkin_en(clkin_en), .sysclk_en(sysclk_en), .sleeping(sleeping)
  );

  // monitor: compare outputs against queued expectation
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      e_v = exp_q.pop_front();
      e_t = tag_q.pop_front();
      a_v = {osc_en, clkin_en, sysclk_en, sleeping};
      checks++;
      if (a_v !== e_v) begin
        errors++;
        $display("FAIL %s actual=%b expected=%b", e_t, a_v, e_v);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
    end
  end

  task automatic tick(input logic [3:0] e, input string r);
    exp_q.push_back(e);
    tag_q.push_back(r);
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    idle_req = 0; int_pend = 0; nmi = 0; ext_rst = 0; wdog_int = 0;
    dbg_wake = 0; gpio_in = '0; cfg_we = 0;
  endtask

  task automatic wr(input logic a, input logic [31:0] d, input logic [3:0] e);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    tick(e, "R2 write");
    cfg_we = 0;
  endtask

  task automatic sleep(input logic [3:0] e, input string r);
    idle_req = 1;
    tick(e, r);
    idle_req = 0;
  endtask

  initial begin
    rst = 1; cfg_addr = 0; cfg_wdata = '0;
    quiet();
    tick(RUN, "R1 reset");
    tick(RUN, "R1 reset");
    rst = 0;
    tick(RUN, "R1 after reset");
    // R1: mask is 0 after reset, so a halt is not left by an input
    wr(0, 32'h2, RUN);
    sleep(HALT, "R1 halt entry");
    gpio_in = '1;
    tick(HALT, "R1 mask zero after reset");
    tick(HALT, "R1 mask zero after reset");
    quiet();
    nmi = 1;
    tick(WOSC, "R7 nmi halt");
    nmi = 0;
    tick(WCLK, "R10 halt step2");
    tick(RUN, "R10 halt step3");

    // light sleep
    wr(1, 32'h0000_0010, RUN);
    wr(0, 32'h0, RUN);
    sleep(LIGHT, "R3 light entry");
    gpio_in = 32'h10; dbg_wake = 1;
    repeat (3) tick(LIGHT, "R5 ignored in light");
    quiet();
    int_pend = 1;
    tick(RUN, "R5 int wake");
    quiet();
    sleep(LIGHT, "R3 light entry");
    wdog_int = 1;
    tick(RUN, "R5 wdog wake");
    quiet();
    sleep(LIGHT, "R3 light entry");
    nmi = 1;
    tick(RUN, "R5 nmi wake");
    quiet();

    // standby with count 2 -> needs 4 samples
    wr(0, (32'd2 << 2) | 32'h1, RUN);
    sleep(STBY, "R4 standby entry");
    int_pend = 1;
    repeat (2) tick(STBY, "R6 int ignored in standby");
    quiet();
    gpio_in = 32'h8;
    repeat (6) tick(STBY, "R9 unselected line");
    gpio_in = 32'h10;
    repeat (3) tick(STBY, "R8 qualifying");
    gpio_in = '0;
    tick(STBY, "R8 drop restarts");
    gpio_in = 32'h10;
    repeat (3) tick(STBY, "R8 qualifying again");
    tick(WCLK, "R8 qualified wake");
    gpio_in = '0;
    tick(RUN, "R10 standby step2");

    // count 0 -> 2 samples
    wr(0, 32'h1, RUN);
    sleep(STBY, "R4 standby entry");
    gpio_in = 32'h10;
    tick(STBY, "R8 count0 first sample");
    tick(WCLK, "R8 count0 wake");
    quiet();
    tick(RUN, "R10 standby step2");
    sleep(STBY, "R4 standby entry");
    dbg_wake = 1;
    tick(WCLK, "R6 dbg wake");
    quiet();
    tick(RUN, "R10 standby step2");
    sleep(STBY, "R4 standby entry");
    wdog_int = 1;
    tick(WCLK, "R6 wdog wake");
    quiet();
    tick(RUN, "R10 standby step2");
    sleep(STBY, "R4 standby entry");
    nmi = 1;
    tick(WCLK, "R6 nmi wake");
    quiet();
    tick(RUN, "R10 standby step2");

    // halt, mode 10
    wr(0, 32'h2, RUN);
    sleep(HALT, "R4 halt entry");
    wdog_int = 1;
    repeat (2) tick(HALT, "R7 wdog ignored in halt");
    quiet();
    int_pend = 1;
    tick(HALT, "R7 int ignored in halt");
    quiet();
    gpio_in = 32'h10;
    tick(WOSC, "R7 unqualified input wake");
    quiet();
    tick(WCLK, "R10 halt step2");
    tick(RUN, "R10 halt step3");

    // halt, mode 11
    wr(0, 32'h3, RUN);
    sleep(HALT, "R2 mode 11 is halt");
    dbg_wake = 1;
    tick(WOSC, "R7 dbg wake");
    quiet();
    tick(WCLK, "R10 halt step2");
    tick(RUN, "R10 halt step3");

    // external reset
    sleep(HALT, "R4 halt entry");
    ext_rst = 1;
    tick(RUN, "R11 ext reset from halt");
    quiet();
    sleep(HALT, "R4 halt entry");
    nmi = 1;
    tick(WOSC, "R7 nmi wake");
    quiet(); ext_rst = 1;
    tick(RUN, "R11 ext reset mid wake");
    quiet();
    wr(0, 32'h1, RUN);
    sleep(STBY, "R4 standby entry");
    ext_rst = 1;
    tick(RUN, "R11 ext reset from standby");
    quiet();
    wr(0, 32'h0, RUN);
    sleep(LIGHT, "R3 light entry");
    ext_rst = 1;
    tick(RUN, "R11 ext reset from light");
    quiet();
    tick(RUN, "R11 stays run");

    @(negedge clk);
    #1;
    finish_run();
  end
endmodule